// File: doc/BRIEF.md
# Load/Store Fault Classifier and Capture

This block sits between the memory port of a load/store unit and the trap logic of the core. It takes one request per cycle: the effective address, whether the request is a load or a store, the access size, whether address translation is on, and the status bits the translation unit returned for that address. One cycle later it reports the outcome for that request. The report is a two-bit reason code plus one flag per fault condition. Alongside them is a one-cycle `done` pulse that marks when they are valid.

The block uses a two-state machine. In **IDLE**, nothing is being reported and every result output holds at zero. The transition **accept** (`req_valid` high) moves it to **REPORT**, where the captured request is classified and `done` is high. From REPORT, the transition **chain** (`req_valid` high again) stays in REPORT to report the next request back to back. The transition **drain** (`req_valid` low) returns to IDLE.

When a reported request raises an exception that is not an instruction-side fault, its address is written to a fault-address register. When that exception is also not a segment fault and not an alignment fault, a fault-status word is written as well. Both registers change on the clock edge that ends the `done` cycle, so the new values are visible in the following cycle. They hold their values until the next qualifying exception or until synchronous reset.

Top module: `ldst_fault_unit`

## Requirements
- R1: `done` is high in exactly the cycle after each clock edge that samples `req_valid` high, and carries that request's result. `reason` encodes 0 = none, 1 = invalid address, 2 = write to read-only memory, 3 = page fault. When `done` is low, `reason`, `exception` and every flag output are zero.
- R2: An aligned store whose address lies in the read-only window [`ROM_BASE`, `ROM_LIMIT`) reports reason 2. An aligned load in the same window reports reason 0 unless another condition applies.
- R3: An aligned load or store whose address is at or above `MEM_LIMIT` reports reason 1.
- R4: When `xlate_en` is high, an aligned access reports reason 3 if its address lies in the null page (all address bits at and above `PAGE_BITS` are zero) or if any of the translation status inputs is high (`xl_invalid`, `xl_badtree`, `xl_perm`, `xl_refchg`, `xl_segment`). When `xlate_en` is low, the null page raises no fault.
- R5: An access whose address is not a multiple of its size (`req_size` 0/1/2/3 means 1/2/4/8 bytes) raises `flag_align` and `exception`. Alignment wins over every other check: `reason` is then 0.
- R6: On a `done` cycle, `flag_ifetch`, `flag_xinvalid`, `flag_badtree`, `flag_perm`, `flag_refchg` and `flag_segment` each equal the matching input sampled with the request. `exception` is high when any flag is high or `reason` is non-zero.
- R7: When several reason conditions apply at once, invalid address wins over page fault, and page fault wins over read-only write.
- R8: `fault_addr` takes the request address after a `done` cycle with `exception` high and `flag_ifetch` low. Otherwise it holds its value.
- R9: `fault_status` is written after a `done` cycle with `exception` high and `flag_ifetch`, `flag_segment` and `flag_align` all low. Otherwise it holds its value. Its bit layout is: bit0 reason was 1, bit1 reason was 2, bit2 null page with translation on, bit3 `xl_invalid`, bit4 `xl_badtree`, bit5 `xl_perm`, bit6 `xl_refchg`, bit7 the access was a store, and all higher bits zero.
- R10: Synchronous reset (`rst` high at a clock edge) returns the machine to IDLE and clears `fault_addr` and `fault_status` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is presented this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Effective address |
| req_size | input | 2 | log2 of the access size in bytes |
| xlate_en | input | 1 | Address translation is enabled |
| ifetch_fault | input | 1 | Instruction-side fault reported with the request |
| xl_invalid | input | 1 | Translation found no valid entry |
| xl_badtree | input | 1 | Translation table structure was malformed |
| xl_perm | input | 1 | Translation permission check failed |
| xl_refchg | input | 1 | Reference/change bit update failed |
| xl_segment | input | 1 | Segment lookup failed |
| done | output | 1 | One-cycle result pulse |
| reason | output | 2 | Fault reason code |
| exception | output | 1 | Any fault in the reported request |
| flag_align | output | 1 | Misaligned access |
| flag_ifetch | output | 1 | Instruction-side fault |
| flag_xinvalid | output | 1 | Translation invalid |
| flag_badtree | output | 1 | Bad translation tree |
| flag_perm | output | 1 | Permission error |
| flag_refchg | output | 1 | Reference/change error |
| flag_segment | output | 1 | Segment fault |
| fault_addr | output | ADDR_W | Captured faulting address |
| fault_status | output | STATUS_W | Captured fault-status word |

## Verification
If the state register gets stuck in REPORT, `done` stays high in a cycle with no request behind it, and the very next result check shows it. If the state register misses an accept, a pulse is lost, and the scoreboard still holds an expected item when the run drains. A request register that latched the wrong fields shows up as a wrong `reason` or a wrong flag on that same `done` cycle. A capture register with a wrong update condition differs from the bench's model in the cycle right after the `done` pulse that should or should not have written it.

// File: rtl/ldst_fault_pkg.sv
package ldst_fault_pkg;

    typedef enum logic [1:0] {
        RSN_NONE     = 2'd0,
        RSN_BAD_ADDR = 2'd1,
        RSN_RO_WRITE = 2'd2,
        RSN_PAGE     = 2'd3
    } fault_rsn_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } fsm_st_e;

    typedef struct packed {
        logic ifetch;
        logic xinvalid;
        logic badtree;
        logic perm;
        logic refchg;
        logic segment;
    } xl_stat_t;

    localparam int STATUS_USED = 8;

endpackage

// File: rtl/ldst_align_chk.sv
module ldst_align_chk #(
    parameter int ADDR_W   = 32,
    parameter int SIZE_LOG = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              misaligned
);
    logic [SIZE_LOG-1:0] bad_bit;

    // Bit i of the address must be zero when the size is larger than 2**i bytes.
    generate
        for (genvar i = 0; i < SIZE_LOG; i++) begin : g_bit
            assign bad_bit[i] = addr[i] && (int'(size) > i);
        end
    endgenerate

    assign misaligned = |bad_bit;
endmodule

// File: rtl/ldst_region_chk.sv
module ldst_region_chk #(
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] MEM_LIMIT = 'h0001_0000,
    parameter logic [ADDR_W-1:0] ROM_BASE  = 'h0000_8000,
    parameter logic [ADDR_W-1:0] ROM_LIMIT = 'h0000_A000,
    parameter int              PAGE_BITS = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_store,
    output logic              out_of_range,
    output logic              ro_write,
    output logic              null_page
);
    assign out_of_range = (addr >= MEM_LIMIT);
    assign ro_write     = is_store && (addr >= ROM_BASE) && (addr < ROM_LIMIT);
    assign null_page    = (addr[ADDR_W-1:PAGE_BITS] == '0);
endmodule

// File: rtl/ldst_fault_capture.sv
module ldst_fault_capture #(
    parameter int ADDR_W   = 32,
    parameter int STATUS_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                upd_addr,
    input  logic                upd_status,
    input  logic [ADDR_W-1:0]   addr_in,
    input  logic [STATUS_W-1:0] status_in,
    output logic [ADDR_W-1:0]   addr_q,
    output logic [STATUS_W-1:0] status_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            status_q <= '0;
        end else begin
            if (upd_addr)   addr_q   <= addr_in;
            if (upd_status) status_q <= status_in;
        end
    end

    // R8: the address register only moves on an update
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(upd_addr)) |-> $stable(addr_q));

    // R9: the status register only moves on an update
    p_status_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(upd_status)) |-> $stable(status_q));

    // R9: a status write always comes with an address write
    p_status_implies_addr_r9: assert property (@(posedge clk) disable iff (rst)
        upd_status |-> upd_addr);
endmodule

// File: rtl/ldst_fault_unit.sv
module ldst_fault_unit
    import ldst_fault_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              STATUS_W  = 32,
    parameter int              PAGE_BITS = 12,
    parameter logic [ADDR_W-1:0] MEM_LIMIT = 'h0001_0000,
    parameter logic [ADDR_W-1:0] ROM_BASE  = 'h0000_8000,
    parameter logic [ADDR_W-1:0] ROM_LIMIT = 'h0000_A000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_store,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic                xlate_en,
    input  logic                ifetch_fault,
    input  logic                xl_invalid,
    input  logic                xl_badtree,
    input  logic                xl_perm,
    input  logic                xl_refchg,
    input  logic                xl_segment,
    output logic                done,
    output logic [1:0]          reason,
    output logic                exception,
    output logic                flag_align,
    output logic                flag_ifetch,
    output logic                flag_xinvalid,
    output logic                flag_badtree,
    output logic                flag_perm,
    output logic                flag_refchg,
    output logic                flag_segment,
    output logic [ADDR_W-1:0]   fault_addr,
    output logic [STATUS_W-1:0] fault_status
);
    localparam int SIZE_LOG = 3;
    localparam int PAD_W    = STATUS_W - STATUS_USED;

    fsm_st_e     state_q, state_d;
    logic        cap_store;
    logic [ADDR_W-1:0] cap_addr;
    logic [1:0]  cap_size;
    logic        cap_xlate;
    xl_stat_t    cap_stat;

    logic        misaligned, out_of_range, ro_write, null_page;
    logic        xl_any, page_hit;
    fault_rsn_e  rsn;
    logic        upd_addr, upd_status;
    logic [STATUS_W-1:0] status_word;

    // State register and request capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cap_store <= 1'b0;
            cap_addr  <= '0;
            cap_size  <= '0;
            cap_xlate <= 1'b0;
            cap_stat  <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                cap_store <= req_store;
                cap_addr  <= req_addr;
                cap_size  <= req_size;
                cap_xlate <= xlate_en;
                cap_stat  <= '{ifetch: ifetch_fault, xinvalid: xl_invalid,
                               badtree: xl_badtree, perm: xl_perm,
                               refchg: xl_refchg, segment: xl_segment};
            end
        end
    end

    // Transitions: accept (IDLE->REPORT), chain (REPORT->REPORT), drain (REPORT->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = req_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    ldst_align_chk #(.ADDR_W(ADDR_W), .SIZE_LOG(SIZE_LOG)) u_align (
        .addr       (cap_addr),
        .size       (cap_size),
        .misaligned (misaligned)
    );

    ldst_region_chk #(
        .ADDR_W(ADDR_W), .MEM_LIMIT(MEM_LIMIT), .ROM_BASE(ROM_BASE),
        .ROM_LIMIT(ROM_LIMIT), .PAGE_BITS(PAGE_BITS)
    ) u_region (
        .addr         (cap_addr),
        .is_store     (cap_store),
        .out_of_range (out_of_range),
        .ro_write     (ro_write),
        .null_page    (null_page)
    );

    assign xl_any   = cap_stat.xinvalid | cap_stat.badtree | cap_stat.perm |
                      cap_stat.refchg | cap_stat.segment;
    assign page_hit = cap_xlate && (null_page || xl_any);

    // Output process
    always_comb begin
        done          = 1'b0;
        rsn           = RSN_NONE;
        flag_align    = 1'b0;
        flag_ifetch   = 1'b0;
        flag_xinvalid = 1'b0;
        flag_badtree  = 1'b0;
        flag_perm     = 1'b0;
        flag_refchg   = 1'b0;
        flag_segment  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_REPORT: begin
                done          = 1'b1;
                flag_align    = misaligned;
                flag_ifetch   = cap_stat.ifetch;
                flag_xinvalid = cap_stat.xinvalid;
                flag_badtree  = cap_stat.badtree;
                flag_perm     = cap_stat.perm;
                flag_refchg   = cap_stat.refchg;
                flag_segment  = cap_stat.segment;
                if (misaligned)        rsn = RSN_NONE;
                else if (out_of_range) rsn = RSN_BAD_ADDR;
                else if (page_hit)     rsn = RSN_PAGE;
                else if (ro_write)     rsn = RSN_RO_WRITE;
                else                   rsn = RSN_NONE;
            end
            default: begin
            end
        endcase
    end

    assign reason    = rsn;
    assign exception = flag_align | flag_ifetch | flag_xinvalid | flag_badtree |
                       flag_perm | flag_refchg | flag_segment | (rsn != RSN_NONE);

    assign upd_addr   = exception && !flag_ifetch;
    assign upd_status = upd_addr && !flag_segment && !flag_align;

    assign status_word = {{PAD_W{1'b0}}, cap_store, cap_stat.refchg, cap_stat.perm,
                          cap_stat.badtree, cap_stat.xinvalid,
                          cap_xlate && null_page,
                          rsn == RSN_RO_WRITE, rsn == RSN_BAD_ADDR};

    ldst_fault_capture #(.ADDR_W(ADDR_W), .STATUS_W(STATUS_W)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .upd_addr   (upd_addr),
        .upd_status (upd_status),
        .addr_in    (cap_addr),
        .status_in  (status_word),
        .addr_q     (fault_addr),
        .status_q   (fault_status)
    );

    // R1: every done pulse follows a sampled request
    p_done_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(req_valid));

    // R1: a sampled request always yields a pulse in the next cycle
    p_req_gives_done_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && state_q == state_q) |=> done);

    // R1: results are quiet outside a done pulse
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !done |-> (reason == 2'd0 && !exception));

    // R2: a read-only code only ever reports a store
    p_ro_is_store_r2: assert property (@(posedge clk) disable iff (rst)
        (done && reason == 2'd2) |-> cap_store);

    // R5: a misaligned report carries no reason code
    p_align_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (done && flag_align) |-> reason == 2'd0);

    // R8: an instruction-side fault never moves the address register
    p_ifetch_keeps_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (done && flag_ifetch) |=> $stable(fault_addr));
endmodule

// File: tb/ldst_fault_unit_tb_top.sv
module ldst_fault_unit_tb_top;
    localparam int          AW        = 32;
    localparam int          SW        = 32;
    localparam logic [31:0] MEM_LIM   = 32'h0001_0000;
    localparam logic [31:0] ROM_LO    = 32'h0000_8000;
    localparam logic [31:0] ROM_HI    = 32'h0000_A000;
    localparam int          WATCHDOG  = 20000;

    typedef struct packed {
        logic [1:0]  rsn;
        logic [6:0]  flg;   // align, ifetch, xinvalid, badtree, perm, refchg, segment
        logic        exc;
        logic        upd_a;
        logic        upd_s;
        logic [31:0] addr;
        logic [31:0] stat;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_store = 1'b0, xlate_en = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_size = '0;
    logic ifetch_fault = 1'b0, xl_invalid = 1'b0, xl_badtree = 1'b0;
    logic xl_perm = 1'b0, xl_refchg = 1'b0, xl_segment = 1'b0;
    logic done, exception;
    logic [1:0] reason;
    logic flag_align, flag_ifetch, flag_xinvalid, flag_badtree, flag_perm, flag_refchg, flag_segment;
    logic [AW-1:0] fault_addr;
    logic [SW-1:0] fault_status;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];
    logic [31:0] m_addr = '0;
    logic [31:0] m_stat = '0;

    always #4 clk = ~clk;

    ldst_fault_unit dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
        .req_addr(req_addr), .req_size(req_size), .xlate_en(xlate_en),
        .ifetch_fault(ifetch_fault), .xl_invalid(xl_invalid), .xl_badtree(xl_badtree),
        .xl_perm(xl_perm), .xl_refchg(xl_refchg), .xl_segment(xl_segment),
        .done(done), .reason(reason), .exception(exception),
        .flag_align(flag_align), .flag_ifetch(flag_ifetch), .flag_xinvalid(flag_xinvalid),
        .flag_badtree(flag_badtree), .flag_perm(flag_perm), .flag_refchg(flag_refchg),
        .flag_segment(flag_segment), .fault_addr(fault_addr), .fault_status(fault_status)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Driver: present one request and push what it must produce
    // stat = {ifetch, xinvalid, badtree, perm, refchg, segment}
    task automatic issue(input string tag, input logic st, input logic [31:0] a,
                         input logic [1:0] sz, input logic xl, input logic [5:0] stat);
        exp_t e;
        logic mis, bad, pg, ro, nul;
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_addr = a; req_size = sz; xlate_en = xl;
        {ifetch_fault, xl_invalid, xl_badtree, xl_perm, xl_refchg, xl_segment} = stat;
        mis = (a % (32'd1 << sz)) != 0;
        nul = (a < 32'h1000);
        bad = a >= MEM_LIM;
        pg  = xl && (nul || (|stat[4:0]));
        ro  = st && a >= ROM_LO && a < ROM_HI;
        e.rsn   = mis ? 2'd0 : bad ? 2'd1 : pg ? 2'd3 : ro ? 2'd2 : 2'd0;
        e.flg   = {mis, stat};
        e.exc   = mis || (e.rsn != 0) || (|stat);
        e.upd_a = e.exc && !stat[5];
        e.upd_s = e.upd_a && !stat[0] && !mis;
        e.addr  = a;
        e.stat  = {24'd0, st, stat[1], stat[2], stat[3], stat[4], xl && nul,
                   e.rsn == 2'd2, e.rsn == 2'd1};
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst) begin
            m_addr = '0;
            m_stat = '0;
        end else if (!finished) begin
            chk(fault_addr == m_addr, "R8", "fault_addr", fault_addr, m_addr);
            chk(fault_status == m_stat, "R9", "fault_status", fault_status, m_stat);
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(reason == e.rsn, t, "reason", reason, e.rsn);
                    chk({flag_align, flag_ifetch, flag_xinvalid, flag_badtree, flag_perm,
                         flag_refchg, flag_segment} == e.flg, "R6", "flags",
                        {flag_align, flag_ifetch, flag_xinvalid, flag_badtree, flag_perm,
                         flag_refchg, flag_segment}, e.flg);
                    chk(exception == e.exc, "R6", "exception", exception, e.exc);
                    if (e.upd_a) m_addr = e.addr;
                    if (e.upd_s) m_stat = e.stat;
                end
            end else begin
                chk(reason == 0 && !exception && !flag_align && !flag_ifetch && !flag_segment,
                    "R1", "quiet outputs", {reason, exception}, 0);
            end
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL R1 watchdog expired actual=%0d expected=0", exp_q.size());
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(done == 0 && reason == 0 && fault_addr == 0 && fault_status == 0,
            "R10", "reset state", {done, reason}, 0);
        rst = 1'b0;
        quiet(2);
        // plain accesses
        issue("R1", 1'b0, 32'h0000_0100, 2'd2, 1'b0, 6'b000000);
        issue("R1", 1'b1, 32'h0000_2008, 2'd3, 1'b0, 6'b000000);
        quiet(2);
        // read-only window
        issue("R2", 1'b1, 32'h0000_8010, 2'd3, 1'b0, 6'b000000);
        issue("R2", 1'b0, 32'h0000_8010, 2'd3, 1'b0, 6'b000000);
        issue("R2", 1'b1, 32'h0000_9FFC, 2'd2, 1'b0, 6'b000000);
        issue("R2", 1'b1, 32'h0000_A000, 2'd2, 1'b0, 6'b000000);
        quiet(1);
        // out of range
        issue("R3", 1'b0, 32'h0002_0000, 2'd2, 1'b0, 6'b000000);
        issue("R3", 1'b1, 32'h0001_0000, 2'd0, 1'b0, 6'b000000);
        issue("R3", 1'b0, 32'h0000_FFFF, 2'd0, 1'b0, 6'b000000);
        quiet(1);
        // null page and translation status
        issue("R4", 1'b0, 32'h0000_0010, 2'd0, 1'b1, 6'b000000);
        issue("R4", 1'b0, 32'h0000_0010, 2'd0, 1'b0, 6'b000000);
        issue("R4", 1'b0, 32'h0000_1000, 2'd2, 1'b1, 6'b000000);
        issue("R4", 1'b1, 32'h0000_3000, 2'd2, 1'b1, 6'b010000);
        quiet(1);
        // alignment for every size
        issue("R5", 1'b1, 32'h0000_0103, 2'd1, 1'b0, 6'b000000);
        issue("R5", 1'b0, 32'h0000_0106, 2'd2, 1'b0, 6'b000000);
        issue("R5", 1'b0, 32'h0000_0104, 2'd3, 1'b0, 6'b000000);
        issue("R5", 1'b0, 32'h0000_0101, 2'd0, 1'b0, 6'b000000);
        issue("R5", 1'b1, 32'h0002_0001, 2'd2, 1'b1, 6'b000100);
        quiet(1);
        // individual flags
        issue("R6", 1'b0, 32'h0000_0200, 2'd2, 1'b1, 6'b000100);
        issue("R6", 1'b0, 32'h0000_4000, 2'd2, 1'b1, 6'b001000);
        issue("R6", 1'b1, 32'h0000_4010, 2'd2, 1'b1, 6'b000010);
        issue("R8", 1'b0, 32'h0000_4440, 2'd2, 1'b0, 6'b100000);
        issue("R9", 1'b0, 32'h0000_5550, 2'd2, 1'b1, 6'b000001);
        issue("R6", 1'b1, 32'h0000_4020, 2'd2, 1'b0, 6'b000010);
        quiet(2);
        // priority
        issue("R7", 1'b1, 32'h0002_0000, 2'd2, 1'b1, 6'b000100);
        issue("R7", 1'b1, 32'h0000_8000, 2'd2, 1'b1, 6'b000100);
        issue("R7", 1'b1, 32'h0000_8000, 2'd2, 1'b0, 6'b000000);
        quiet(3);
        // reset clears capture registers
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(fault_addr == 0 && fault_status == 0 && done == 0, "R10", "cleared by reset",
            {fault_addr, fault_status}, 0);
        rst = 1'b0;
        issue("R10", 1'b0, 32'h0000_0300, 2'd2, 1'b0, 6'b000000);
        quiet(4);
        chk(exp_q.size() == 0, "R1", "all results seen", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule